// File: doc/BRIEF.md
# Configurable Clarke Input Converter

This block turns a set of signed phase samples into an orthogonal cosine/sine pair (direct and quadrature components) ahead of any angle rotation stage. The pair it produces is not rotated, so it can be used on its own or passed to a later rotation block. A 2-bit format select chooses how the three phase ports are read. In the orthogonal format, the caller already supplies cosine and sine and the block passes them through. In the three-input format, the ports carry a balanced set at 0, +120 and +240 degrees. In the two-input format, only the +120 and +240 phases are supplied and the 0-degree phase is rebuilt from them.

Samples and results are 16-bit signed Q1.14. Intermediate values carry two guard bits, and both outputs saturate to full scale. A sample is taken when `in_valid` is high. Its result shows up on the outputs together with `out_valid` exactly two clock cycles later. A new sample may be accepted every cycle. Between results, the outputs keep their last value.

Top module: `clarke_front`

## Requirements
- R1: With `fmt` = 2'b00 (orthogonal pass-through), `dir_out` equals `ph_a` and `quad_out` equals `ph_b`, and `ph_c` has no effect.
- R2: With `fmt` = 2'b01 (three inputs), `dir_out` equals `ph_a` and `quad_out` equals floor((`ph_c` − `ph_b`) × 18919 / 2^15), saturated. 18919 is 1/√3 in Q0.15.
- R3: With `fmt` = 2'b10 (two inputs), `dir_out` equals −(`ph_b` + `ph_c`), saturated. `quad_out` is computed as in R2. `ph_a` has no effect.
- R4: `fmt` = 2'b11 gives exactly the results of 2'b01.
- R5: Any result above 32767 is output as 32767, and any result below −32768 is output as −32768. The intermediate values do not wrap.
- R6: `out_valid` is high in a cycle exactly when `in_valid` was high two rising edges earlier. The outputs then carry that sample's result.
- R7: When no result is due, `dir_out` and `quad_out` hold their previous values. This holds whatever the inputs do in that time.
- R8: After reset, `out_valid`, `dir_out` and `quad_out` are all zero.
- R9: Samples offered on consecutive cycles, in any mix of formats, each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| fmt | input | 2 | Input format select (00 orthogonal, 01 three-input, 10 two-input, 11 as 01) |
| ph_a | input | 16 | 0-degree phase, or cosine in the orthogonal format (Q1.14) |
| ph_b | input | 16 | +120-degree phase, or sine in the orthogonal format (Q1.14) |
| ph_c | input | 16 | +240-degree phase (Q1.14) |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| dir_out | output | 16 | Direct (cosine) component (Q1.14) |
| quad_out | output | 16 | Quadrature (sine) component (Q1.14) |

## Verification
Each result is due at the second rising edge after the edge that takes its sample. The bench drives inputs on falling edges and marks each expected result as due two falling edges later. On every falling edge it compares all three outputs with its model: the expected values when a result is due, and the held values otherwise. Idle cycles with changing inputs therefore test the holding behaviour and the absence of spurious strobes cycle by cycle. The saturation corners and the reserved format code are fed through the same timed comparison.

// File: rtl/clarke_pkg.sv
package clarke_pkg;
  typedef enum logic [1:0] {
    FMT_ORTHO = 2'b00,
    FMT_TRI3  = 2'b01,
    FMT_TRI2  = 2'b10,
    FMT_RSVD  = 2'b11
  } fmt_e;
endpackage

// File: rtl/clarke_select.sv
// Stage 1: decode the input format, rebuild the missing phase, form the difference.
module clarke_select #(
  parameter int W     = 16,
  parameter int GUARD = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [1:0]                  fmt,
  input  logic signed [W-1:0]         ph_a,
  input  logic signed [W-1:0]         ph_b,
  input  logic signed [W-1:0]         ph_c,
  output logic                        s1_valid,
  output logic                        s1_bypass,
  output logic signed [W+GUARD-1:0]   s1_dir,
  output logic signed [W+GUARD-1:0]   s1_src
);
  import clarke_pkg::*;
  localparam int WG = W + GUARD;

  function automatic logic signed [WG-1:0] widen(input logic signed [W-1:0] x);
    return {{GUARD{x[W-1]}}, x};
  endfunction

  // -(b+c): the 0-degree phase of a balanced set
  function automatic logic signed [WG-1:0] rebuild_a(input logic signed [W-1:0] b,
                                                     input logic signed [W-1:0] c);
    return -(widen(b) + widen(c));
  endfunction

  fmt_e                 fmt_q;
  logic signed [WG-1:0] dir_d, src_d;
  logic                 byp_d;

  always_comb begin
    fmt_q = fmt_e'(fmt);
    byp_d = (fmt_q == FMT_ORTHO);
    dir_d = (fmt_q == FMT_TRI2) ? rebuild_a(ph_b, ph_c) : widen(ph_a);
    src_d = byp_d ? widen(ph_b) : (widen(ph_c) - widen(ph_b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b0;
      s1_dir    <= '0;
      s1_src    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_bypass <= byp_d;
        s1_dir    <= dir_d;
        s1_src    <= src_d;
      end
    end
  end
endmodule

// File: rtl/clarke_scale.sv
// Stage 2: scale the difference by 1/sqrt(3), saturate, register the outputs.
module clarke_scale #(
  parameter int W       = 16,
  parameter int GUARD   = 2,
  parameter int K_VAL   = 18919,
  parameter int K_SHIFT = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s1_valid,
  input  logic                        s1_bypass,
  input  logic signed [W+GUARD-1:0]   s1_dir,
  input  logic signed [W+GUARD-1:0]   s1_src,
  output logic                        out_valid,
  output logic signed [W-1:0]         dir_out,
  output logic signed [W-1:0]         quad_out
);
  localparam int WG = W + GUARD;
  localparam int PW = WG + K_SHIFT + 2;
  localparam logic signed [PW-1:0] KV   = PW'(K_VAL);
  localparam logic signed [PW-1:0] PMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] PMIN = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  function automatic logic signed [PW-1:0] to_pw(input logic signed [WG-1:0] x);
    return {{(PW-WG){x[WG-1]}}, x};
  endfunction

  function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] x);
    if (x > PMAX) return PMAX[W-1:0];
    if (x < PMIN) return PMIN[W-1:0];
    return x[W-1:0];
  endfunction

  function automatic logic signed [PW-1:0] scale_inv_sqrt3(input logic signed [WG-1:0] d);
    logic signed [PW-1:0] prod;
    prod = to_pw(d) * KV;
    return prod >>> K_SHIFT;
  endfunction

  logic signed [W-1:0] dir_d, quad_d;

  always_comb begin
    dir_d  = clip(to_pw(s1_dir));
    quad_d = s1_bypass ? clip(to_pw(s1_src)) : clip(scale_inv_sqrt3(s1_src));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dir_out   <= '0;
      quad_out  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        dir_out  <= dir_d;
        quad_out <= quad_d;
      end
    end
  end
endmodule

// File: rtl/clarke_front.sv
module clarke_front #(
  parameter int W       = 16,
  parameter int GUARD   = 2,
  parameter int K_VAL   = 18919,
  parameter int K_SHIFT = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          fmt,
  input  logic signed [W-1:0] ph_a,
  input  logic signed [W-1:0] ph_b,
  input  logic signed [W-1:0] ph_c,
  output logic                out_valid,
  output logic signed [W-1:0] dir_out,
  output logic signed [W-1:0] quad_out
);
  localparam int WG = W + GUARD;

  // stage-1 events, named for the checker
  logic                 s1_valid;
  logic                 s1_bypass;
  logic signed [WG-1:0] s1_dir;
  logic signed [WG-1:0] s1_src;

  clarke_select #(.W(W), .GUARD(GUARD)) u_select (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .s1_valid(s1_valid), .s1_bypass(s1_bypass), .s1_dir(s1_dir), .s1_src(s1_src)
  );

  clarke_scale #(.W(W), .GUARD(GUARD), .K_VAL(K_VAL), .K_SHIFT(K_SHIFT)) u_scale (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_bypass(s1_bypass), .s1_dir(s1_dir), .s1_src(s1_src),
    .out_valid(out_valid), .dir_out(dir_out), .quad_out(quad_out)
  );
endmodule

// File: rtl/clarke_front_chk.sv
module clarke_front_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          fmt,
  input logic signed [W-1:0] ph_a,
  input logic signed [W-1:0] ph_b,
  input logic signed [W-1:0] ph_c,
  input logic                s1_valid,
  input logic                s1_bypass,
  input logic                out_valid,
  input logic signed [W-1:0] dir_out,
  input logic signed [W-1:0] quad_out
);
  // R6: a sample strobe reaches stage 1 and then the output
  p_stage1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  p_stage2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);

  // R7: outputs hold when no result is due
  p_hold_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(dir_out));
  p_hold_quad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(quad_out));

  // R1: pass-through of the sine input
  p_bypass_quad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b00) |-> ##2 (quad_out == $past(ph_b, 2)));
  p_bypass_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b00) |-> ##2 (dir_out == $past(ph_a, 2)));
  p_bypass_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b00) |=> s1_bypass);

  // R3: equal and opposite remaining phases rebuild a zero first phase
  p_rebuild_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'b10 && ph_b == -ph_c && ph_b != {1'b1, {(W-1){1'b0}}})
      |-> ##2 (dir_out == '0));

  // R8: nothing valid right after reset
  p_reset_r8: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);
endmodule

bind clarke_front clarke_front_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
  .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
  .s1_valid(s1_valid), .s1_bypass(s1_bypass),
  .out_valid(out_valid), .dir_out(dir_out), .quad_out(quad_out)
);

// File: tb/clarke_front_bench.sv
module clarke_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic signed [15:0] ph_a = '0, ph_b = '0, ph_c = '0;
  logic out_valid;
  logic signed [15:0] dir_out, quad_out;

  always #4 clk = ~clk;

  clarke_front u_clarke_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .out_valid(out_valid), .dir_out(dir_out), .quad_out(quad_out)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  int    q_due[$];
  int    q_dir[$];
  int    q_quad[$];
  string q_tag[$];
  int    held_dir = 0;
  int    held_quad = 0;

  function automatic int clamp16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic int ref_dir(int f, int a, int b, int c);
    if (f == 2) return clamp16(-(longint'(b) + longint'(c)));
    return a;
  endfunction

  function automatic int ref_quad(int f, int b, int c);
    longint p;
    if (f == 0) return b;
    p = (longint'(c) - longint'(b)) * 18919;
    return clamp16(p >>> 15);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare_now();
    bit    ev;
    string tg;
    ev = 1'b0;
    tg = "R7";
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      ev = 1'b1;
      void'(q_due.pop_front());
      held_dir  = q_dir.pop_front();
      held_quad = q_quad.pop_front();
      tg = q_tag.pop_front();
    end
    check(ev ? "R6" : "R6/R7", "out_valid", int'(out_valid), int'(ev));
    check(tg, "dir_out", int'(dir_out), held_dir);
    check(tg, "quad_out", int'(quad_out), held_quad);
  endtask

  task automatic step(bit v, int f, int a, int b, int c, string tag);
    @(negedge clk);
    cyc++;
    compare_now();
    in_valid = v;
    fmt  = 2'(f);
    ph_a = 16'(a);
    ph_b = 16'(b);
    ph_c = 16'(c);
    if (v) begin
      q_due.push_back(cyc + 2);
      q_dir.push_back(ref_dir(f, a, b, c));
      q_quad.push_back(ref_quad(f, b, c));
      q_tag.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      step(1'b0, i % 4, 1111 * (i + 3), -777 * (i + 1), 5000 - 999 * i, "R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (4) @(negedge clk);
    // R8: reset values
    check("R8", "out_valid", int'(out_valid), 0);
    check("R8", "dir_out", int'(dir_out), 0);
    check("R8", "quad_out", int'(quad_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: orthogonal pass-through, ph_c has no effect
    step(1, 0, 12000, -5000, 31000, "R1");
    step(1, 0, -32768, 32767, -20000, "R1");
    idle(3);

    // R2: three-input format
    step(1, 1, 14189, -14189, 0, "R2");
    step(1, 1, 0, 14189, -14189, "R2");
    step(1, 1, -16384, 8192, 8192, "R2");
    idle(2);

    // R3: two-input format, ph_a has no effect
    step(1, 2, 9999, -14189, 0, "R3");
    step(1, 2, -123, 8192, 8192, "R3");
    step(1, 2, 32767, 5000, -5000, "R3");
    idle(2);

    // R4: reserved code behaves as three-input
    step(1, 3, 14189, -14189, 0, "R4");
    step(1, 3, -16384, 8192, 8192, "R4");
    step(1, 3, 321, 20000, -12000, "R4");
    idle(2);

    // R5: saturation corners
    step(1, 1, 0, -32768, 32767, "R5");
    step(1, 1, 0, 32767, -32768, "R5");
    step(1, 2, 0, -32768, -32768, "R5");
    step(1, 2, 0, 32767, 32767, "R5");
    idle(5);

    // R9: back-to-back samples in mixed formats
    s = 12345;
    for (int i = 0; i < 300; i++) begin
      int a, b, c;
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      a = (s % 65536) - 32768;
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      b = (s % 65536) - 32768;
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      c = (s % 65536) - 32768;
      step(1, i % 4, a, b, c, "R9");
      if (i % 37 == 36) idle(1);
    end
    idle(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule